// File: doc/BRIEF.md
# Two-Digit BCD Modulo-60 Counter

This block counts from 00 to 59 in binary-coded decimal and wraps back to 00. The least significant digit is a decade stage. The most significant digit is a modulo-6 stage. That stage steps only on the clock edge where the decade stage rolls from 9 to 0. Typical uses are the seconds or minutes field of a time-of-day chain, and any other place where a sixty-state count has to be shown directly in decimal.

Both digits share four controls. An active-low clear acts at once and does not wait for the clock. An active-low load is sampled on the rising edge and copies a two-digit value into the counter. A count enable lets the counter advance. A terminal carry output marks the last state of the cycle while counting is enabled, so that a following counter can be stepped from it.

Top module: `bcd_mod60_counter`

## Requirements
- R1: While `clr_n` is low, both digits read 0 at once, without waiting for a clock edge, whatever `load_n` and `cnt_en` are. Clear outranks load.
- R2: On a rising edge with `load_n` low and `clr_n` high, `units` takes `load_units` and `tens` takes `load_tens`. This happens whatever `cnt_en` is; load outranks counting.
- R3: With `cnt_en` high and `load_n` high, `units` steps 0,1,…,9 and returns to 0 on the edge after 9.
- R4: `tens` changes only on the edge where `units` wraps from 9 to 0 under enable. On every other counting edge it keeps its value.
- R5: `tens` steps 0 to 5 and then returns to 0. From 58, two enabled edges give 59 and then 00.
- R6: With `cnt_en` low and `load_n` high, both digits hold their value on every edge.
- R7: `carry_out` is combinational. It is 1 exactly when the count is 59 (`units`=9, `tens`=5) and `cnt_en` is 1, and 0 otherwise.
- R8: A loaded `units` value from 10 to 15 steps by one on each enabled edge, and the step after 15 gives 0. `carry_out` stays 0 at those values and `tens` does not change.
- R9: A loaded `tens` value of 6 or 7 steps by one when the units digit wraps, and the step after 7 gives 0. `carry_out` stays 0 at those values, including at 79.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable, active high |
| load_units | input | 4 | BCD value loaded into the units digit |
| load_tens | input | 3 | Value loaded into the tens digit |
| units | output | 4 | Units digit |
| tens | output | 3 | Tens digit |
| carry_out | output | 1 | Terminal carry: count is 59 and enable is high |

## Verification
The bench goes after the boundaries of the count:
- The 59-to-00 rollover. A design that wrapped the tens digit at the wrong value would reach 60, or return to 0 from 49.
- The same-edge handover from units to tens. A design that added a register stage to the carry would show 50 for a cycle, or advance the tens digit one edge late.
- Clear and load asserted together, and load asserted with enable high. A design with the priorities inverted would show the loaded value, or the loaded value plus one.
- Out-of-range loads, such as 13 in the units digit or 6 and 7 in the tens digit. A design that decoded carry from too few bits would raise `carry_out` at 79 or move the tens digit early.

// File: rtl/bcd_mod60_pkg.sv
package bcd_mod60_pkg;

    localparam int UNITS_W   = 4;
    localparam int UNITS_MOD = 10;
    localparam int TENS_W    = 3;
    localparam int TENS_MOD  = 6;

    // Action selected for a digit stage on the next rising edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_INC  = 2'd2,
        ACT_WRAP = 2'd3
    } stage_act_e;

endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_mod60_pkg::*;
#(
    parameter int WIDTH   = 4,
    parameter int MODULUS = 10
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             carry
);

    localparam logic [WIDTH-1:0] TERM_VAL = WIDTH'(MODULUS - 1);
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } digit_state_t;

    digit_state_t state_d, state_q;
    stage_act_e   act;
    logic         at_term;

    // Full compare, so out-of-range codes never decode as the last state
    assign at_term = (state_q.val == TERM_VAL);

    always_comb begin
        if (!load_n)
            act = ACT_LOAD;
        else if (!en)
            act = ACT_HOLD;
        else if (at_term)
            act = ACT_WRAP;
        else
            act = ACT_INC;

        state_d = state_q;
        unique case (act)
            ACT_LOAD: state_d.val = din;
            ACT_WRAP: state_d.val = '0;
            ACT_INC:  state_d.val = state_q.val + ONE;
            default:  state_d.val = state_q.val;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign q     = state_q.val;
    assign carry = at_term & en;

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (q == $past(din)));                                        // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !en) |=> $stable(q));                                       // R6
    AST_WRAP_AT_TERM: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en && q == TERM_VAL) |=> (q == '0));                        // R3
    AST_CARRY_ONLY_AT_TERM: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> (en && q == TERM_VAL));                                      // R7

endmodule

// File: rtl/bcd_mod60_counter.sv
module bcd_mod60_counter
    import bcd_mod60_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               cnt_en,
    input  logic [UNITS_W-1:0] load_units,
    input  logic [TENS_W-1:0]  load_tens,
    output logic [UNITS_W-1:0] units,
    output logic [TENS_W-1:0]  tens,
    output logic               carry_out
);

    logic units_carry;
    logic tens_carry;

    bcd_digit_stage #(
        .WIDTH   (UNITS_W),
        .MODULUS (UNITS_MOD)
    ) u_units (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .en     (cnt_en),
        .din    (load_units),
        .q      (units),
        .carry  (units_carry)
    );

    // Tens stage is enabled only by the units ripple carry
    bcd_digit_stage #(
        .WIDTH   (TENS_W),
        .MODULUS (TENS_MOD)
    ) u_tens (
        .clk    (clk),
        .clr_n  (clr_n),
        .load_n (load_n),
        .en     (units_carry),
        .din    (load_tens),
        .q      (tens),
        .carry  (tens_carry)
    );

    assign carry_out = tens_carry;

    AST_CLEAR_ZEROES: assert property (@(posedge clk)
        !clr_n |-> (units == '0 && tens == '0));                               // R1
    AST_TENS_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && units == UNITS_W'(UNITS_MOD - 1))) |=> $stable(tens)); // R4
    AST_CARRY_AT_59: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (cnt_en && units == UNITS_W'(9) && tens == TENS_W'(5)));  // R7

endmodule

// File: tb/sim_bcd_mod60_counter.sv
`timescale 1ns/1ps
module sim_bcd_mod60_counter;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] load_units = '0;
    logic [2:0] load_tens = '0;
    logic [3:0] units;
    logic [2:0] tens;
    logic       carry_out;

    int n_checks = 0;
    int n_fail = 0;
    int m_u = 0;
    int m_t = 0;

    always #4 clk = ~clk;

    bcd_mod60_counter u0 (
        .clk        (clk),
        .clr_n      (clr_n),
        .load_n     (load_n),
        .cnt_en     (cnt_en),
        .load_units (load_units),
        .load_tens  (load_tens),
        .units      (units),
        .tens       (tens),
        .carry_out  (carry_out)
    );

    task automatic check(input string req, input int eu, input int et, input int ec);
        n_checks++;
        if (units !== 4'(eu) || tens !== 3'(et) || carry_out !== 1'(ec)) begin
            n_fail++;
            $display("FAIL %s: got units=%0d tens=%0d carry=%0b, expected units=%0d tens=%0d carry=%0d",
                     req, units, tens, carry_out, eu, et, ec);
        end
    endtask

    // One clock: inputs set at negedge, outputs sampled 2 ns after the rising edge
    task automatic step(input logic en, input logic ld, input int lu, input int lt);
        @(negedge clk);
        cnt_en = en; load_n = ld; load_units = 4'(lu); load_tens = 3'(lt);
        @(posedge clk);
        #2;
        if (!ld) begin
            m_u = lu; m_t = lt;
        end else if (en) begin
            if (m_u == 9) begin
                m_u = 0;
                m_t = (m_t + 1) % 8;
                if (m_t == 6) m_t = 0;
            end else
                m_u = (m_u + 1) % 16;
        end
    endtask

    function automatic int exp_carry();
        return (m_u == 9 && m_t == 5 && cnt_en) ? 1 : 0;
    endfunction

    task automatic t_reset();
        #2;
        check("R1 reset", 0, 0, 0);
        @(negedge clk); clr_n = 1'b1;
        m_u = 0; m_t = 0;
    endtask

    task automatic t_full_cycle();
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 1'b1, 0, 0);
            check("R3/R4/R5 count", m_u, m_t, exp_carry());
        end
        check("R5 full cycle back to 00", 0, 0, 0);
    endtask

    task automatic t_rollover_58();
        step(1'b0, 1'b0, 8, 5);
        check("R2 load 58", 8, 5, 0);
        step(1'b1, 1'b1, 0, 0);
        check("R5/R7 59 with carry", 9, 5, 1);
        step(1'b1, 1'b1, 0, 0);
        check("R5 59 to 00", 0, 0, 0);
    endtask

    task automatic t_units_to_tens();
        step(1'b0, 1'b0, 9, 2);
        step(1'b1, 1'b1, 0, 0);
        check("R4 tens steps on units wrap", 0, 3, 0);
        step(1'b1, 1'b1, 0, 0);
        check("R4 tens holds mid decade", 1, 3, 0);
    endtask

    task automatic t_hold_and_carry_gate();
        step(1'b0, 1'b0, 9, 5);
        check("R7 carry low when disabled", 9, 5, 0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b1, 0, 0);
            check("R6 hold", 9, 5, 0);
        end
        @(negedge clk); cnt_en = 1'b1; #1;
        check("R7 carry combinational on enable", 9, 5, 1);
    endtask

    task automatic t_load_priority();
        step(1'b0, 1'b0, 3, 1);
        step(1'b1, 1'b0, 4, 2);
        check("R2 load beats enable", 4, 2, 0);
    endtask

    task automatic t_clear_async();
        step(1'b0, 1'b0, 7, 3);
        check("R2 load 37", 7, 3, 0);
        @(negedge clk); #1;
        clr_n = 1'b0; #1;
        check("R1 clear without clock edge", 0, 0, 0);
        load_n = 1'b0; load_units = 4'd5; load_tens = 3'd4; cnt_en = 1'b1;
        @(posedge clk); #2;
        check("R1 clear beats load", 0, 0, 0);
        @(negedge clk); clr_n = 1'b1; load_n = 1'b1;
        m_u = 0; m_t = 0;
    endtask

    task automatic t_bad_units();
        step(1'b0, 1'b0, 13, 2);
        check("R8 load 2/13", 13, 2, 0);
        step(1'b1, 1'b1, 0, 0);
        check("R8 13 to 14", 14, 2, 0);
        step(1'b1, 1'b1, 0, 0);
        check("R8 14 to 15", 15, 2, 0);
        step(1'b1, 1'b1, 0, 0);
        check("R8 15 to 0, tens kept", 0, 2, 0);
    endtask

    task automatic t_bad_tens();
        step(1'b0, 1'b0, 9, 6);
        step(1'b1, 1'b1, 0, 0);
        check("R9 tens 6 to 7", 0, 7, 0);
        step(1'b0, 1'b0, 9, 7);
        @(negedge clk); cnt_en = 1'b1; #1;
        check("R9 no carry at 79", 9, 7, 0);
        step(1'b1, 1'b1, 0, 0);
        check("R9 79 to 00", 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_rollover_58();
        t_units_to_tens();
        t_hold_and_carry_gate();
        t_load_priority();
        t_clear_async();
        t_bad_units();
        t_bad_tens();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule